// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Window

This block gives a host a narrow, byte-wide indirect view onto a small bank of control registers that belong to a clock synthesizer. The host never addresses the bank directly. Instead it writes an address byte that names a register and carries a write-enable flag, and then moves one data byte in or out through a second byte lane. The bank holds four pixel-clock feedback-divider registers at consecutive indices, one register that packs four 2-bit post-divider codes, a reference-divider register, a general control register, an extended control register and a 2-bit clock-select register.

The stored values are brought out continuously for the downstream clock logic. The feedback divider and the post-divider code shown on the outputs are the ones that belong to the clock chosen by the clock-select register. The reference, general and extended control bytes are shown as they are stored.

The host bus is a single 16-bit word with two byte strobes. Lane 0, bits [7:0], is the address byte. Lane 1, bits [15:8], is the data byte. A register write takes three host cycles: the address byte with write-enable set, then the data byte, then the address byte again with write-enable clear. A read is an address-byte write with write-enable clear, followed by sampling lane 1 of the read data.

Top module: `pll_reg_window`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears every bank register and the address byte. After reset every output reads zero, and host_rdata reads 0x0000.
- R2: A host write with host_be[0] set stores the address byte. The register index is taken from bits [7:2] and write-enable from bit 1. Bit 0 is not stored. The stored byte reads back on host_rdata[7:0]. The address byte keeps its value in cycles with no lane-0 write.
- R3: A host write with host_be[1] set, while the stored write-enable bit is 1, loads host_wdata[15:8] into the register named by the stored index. The new value is visible on the outputs one cycle later.
- R4: A data-lane write made while the stored write-enable bit is 0 changes no register.
- R5: host_rdata[15:8] always shows the register named by the stored index. Indices with no register return 0x00.
- R6: The feedback-divider registers sit at indices 6, 7, 8 and 9, one for each clock 0 to 3. sel_fb_div shows the register that belongs to the clock in clk_sel.
- R7: The post-divider register is at index 5. Clock n uses bits [2n+1:2n] of it, and sel_post_code shows the field of the clock in clk_sel.
- R8: The clock-select register is at index 1 and holds only bits [1:0] of the written byte. It reads back with bits [7:2] zero.
- R9: The reference divider is at index 2, general control at index 3 and extended control at index 4. A write to an index with no register has no effect on any register.
- R10: When both lanes are written in one host cycle, the data byte goes to the register selected by the address byte that was stored before that cycle. It is gated by the write-enable bit stored before that cycle. The new address byte takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 2 | Byte strobes: bit 0 = address lane, bit 1 = data lane |
| host_wdata | input | 16 | Write data: [7:0] address byte, [15:8] data byte |
| host_rdata | output | 16 | Read data: [7:0] stored address byte, [15:8] selected register |
| clk_sel | output | 2 | Stored clock-select value |
| sel_fb_div | output | 8 | Feedback divider of the selected clock |
| sel_post_code | output | 2 | Post-divider code of the selected clock |
| ref_div | output | 8 | Reference divider |
| gen_ctl | output | 8 | General control byte |
| ext_ctl | output | 8 | Extended control byte |

## Verification
The hardest case to reach is a cycle that writes both byte lanes at once. In that cycle the data byte must follow the index and write-enable stored before the cycle, not the address byte arriving with it. The stimulus first parks the address on one writable register with write-enable set. It then issues a combined write whose address byte names a second register. The check confirms that only the first register changes and that the second one takes the next data-only write. Ignored writes are checked the same way: the target register, and registers that are not targeted, are read back through the window.

// File: rtl/pllwin_pkg.sv
// Package: shared constants for the indirect clock-register window.
// Assumes the address byte layout {index, write-enable, spare}.
package pllwin_pkg;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = 6;
    localparam int NUM_CLK   = 4;
    localparam int POST_W    = 2;
    localparam int SEL_W     = $clog2(NUM_CLK);
    // Register indices (fixed so that host software can rely on them)
    localparam int IDX_SEL   = 1;
    localparam int IDX_REF   = 2;
    localparam int IDX_GEN   = 3;
    localparam int IDX_EXT   = 4;
    localparam int IDX_POST  = 5;
    localparam int IDX_FB0   = 6;
    // Address byte fields
    localparam int WEN_BIT   = 1;
    localparam int IDX_LSB   = 2;
endpackage

// File: rtl/pllwin_addr_port.sv
// Module: pllwin_addr_port
// Holds the address byte written on lane 0 and splits it into the
// register index and the write-enable flag. The spare low bit is dropped.
// Assumes DATA_W == IDX_W + IDX_LSB.
module pllwin_addr_port
    import pllwin_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_wr,
    input  logic [DW-1:0] addr_in,
    output logic [DW-1:0] addr_q,
    output logic [IW-1:0] idx,
    output logic          wen
);
    localparam logic [DW-1:0] KEEP_MASK = ~DW'(1);

    // Capture the address byte, clearing the spare bit
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_wr) addr_q <= addr_in & KEEP_MASK;
    end

    // Field split of the stored byte
    always_comb begin
        idx = addr_q[IDX_LSB +: IW];
        wen = addr_q[WEN_BIT];
    end

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_wr |=> $stable(addr_q));
endmodule

// File: rtl/pllwin_reg_bank.sv
// Module: pllwin_reg_bank
// The register bank behind the window. One gated write port; each
// register decodes its own index. Feedback dividers repeat per clock.
// Assumes data_wr is already qualified by the stored write-enable.
module pllwin_reg_bank
    import pllwin_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W,
    parameter int NC = NUM_CLK,
    parameter int SW = SEL_W,
    parameter int PW = POST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [IW-1:0]    idx,
    input  logic [DW-1:0]    wdata,
    output logic [NC*DW-1:0] fb_q,
    output logic [DW-1:0]    post_q,
    output logic [DW-1:0]    ref_q,
    output logic [DW-1:0]    gen_q,
    output logic [DW-1:0]    ext_q,
    output logic [SW-1:0]    sel_q
);
    localparam logic [IW-1:0] A_SEL  = IW'(IDX_SEL);
    localparam logic [IW-1:0] A_REF  = IW'(IDX_REF);
    localparam logic [IW-1:0] A_GEN  = IW'(IDX_GEN);
    localparam logic [IW-1:0] A_EXT  = IW'(IDX_EXT);
    localparam logic [IW-1:0] A_POST = IW'(IDX_POST);

    // Clock-select register keeps only its low field
    always_ff @(posedge clk) begin
        if (!rst_n)                        sel_q <= '0;
        else if (data_wr && idx == A_SEL)  sel_q <= wdata[SW-1:0];
    end

    // Single-byte control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            gen_q  <= '0;
            ext_q  <= '0;
            post_q <= '0;
        end else if (data_wr) begin
            if (idx == A_REF)  ref_q  <= wdata;
            if (idx == A_GEN)  gen_q  <= wdata;
            if (idx == A_EXT)  ext_q  <= wdata;
            if (idx == A_POST) post_q <= wdata;
        end
    end

    // Per-clock feedback divider registers at consecutive indices
    for (genvar g = 0; g < NC; g++) begin : g_fb
        localparam logic [IW-1:0] A_FB = IW'(IDX_FB0 + g);
        always_ff @(posedge clk) begin
            if (!rst_n)                       fb_q[g*DW +: DW] <= '0;
            else if (data_wr && idx == A_FB)  fb_q[g*DW +: DW] <= wdata;
        end
    end

    assert_gated_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable({fb_q, post_q, ref_q, gen_q, ext_q, sel_q}));

    assert_ref_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx == A_REF) |=> ref_q == $past(wdata));

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ref_q == '0 && gen_q == '0 && fb_q == '0));
endmodule

// File: rtl/pllwin_read_mux.sv
// Module: pllwin_read_mux
// Returns the register named by the stored index; zero for holes.
// Assumes the selector register is narrower than the data byte.
module pllwin_read_mux
    import pllwin_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W,
    parameter int NC = NUM_CLK,
    parameter int SW = SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    idx,
    input  logic [NC*DW-1:0] fb_q,
    input  logic [DW-1:0]    post_q,
    input  logic [DW-1:0]    ref_q,
    input  logic [DW-1:0]    gen_q,
    input  logic [DW-1:0]    ext_q,
    input  logic [SW-1:0]    sel_q,
    output logic [DW-1:0]    rd_byte
);
    localparam logic [IW-1:0] A_END = IW'(IDX_FB0 + NC);

    // Index decode for the read lane
    always_comb begin
        rd_byte = '0;
        if (idx == IW'(IDX_SEL))  rd_byte = DW'(sel_q);
        if (idx == IW'(IDX_REF))  rd_byte = ref_q;
        if (idx == IW'(IDX_GEN))  rd_byte = gen_q;
        if (idx == IW'(IDX_EXT))  rd_byte = ext_q;
        if (idx == IW'(IDX_POST)) rd_byte = post_q;
        for (int n = 0; n < NC; n++) begin
            if (idx == IW'(IDX_FB0 + n)) rd_byte = fb_q[n*DW +: DW];
        end
    end

    assert_hole_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == '0 || idx >= A_END) |-> rd_byte == '0);

    assert_sel_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IW'(IDX_SEL)) |-> rd_byte[DW-1:SW] == '0);
endmodule

// File: rtl/pllwin_clk_view.sv
// Module: pllwin_clk_view
// Picks the feedback divider and the packed post-divider code that
// belong to the selected clock, for the downstream clock logic.
// Assumes NC * PW fits in one data byte.
module pllwin_clk_view
    import pllwin_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NC = NUM_CLK,
    parameter int SW = SEL_W,
    parameter int PW = POST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    sel_q,
    input  logic [NC*DW-1:0] fb_q,
    input  logic [DW-1:0]    post_q,
    output logic [DW-1:0]    sel_fb,
    output logic [PW-1:0]    sel_post
);
    // Per-clock field selection
    always_comb begin
        sel_fb   = '0;
        sel_post = '0;
        for (int n = 0; n < NC; n++) begin
            if (sel_q == SW'(n)) begin
                sel_fb   = fb_q[n*DW +: DW];
                sel_post = post_q[n*PW +: PW];
            end
        end
    end

    assert_post_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sel_q) && $stable(post_q)) |-> $stable(sel_post));

    assert_fb_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sel_q) && $stable(fb_q)) |-> $stable(sel_fb));
endmodule

// File: rtl/pll_reg_window.sv
// Module: pll_reg_window
// Top of the indirect register window: address port, register bank,
// read multiplexer and selected-clock view. The data lane is gated by
// the write-enable stored before the current cycle.
module pll_reg_window
    import pllwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [1:0]          host_be,
    input  logic [2*DATA_W-1:0] host_wdata,
    output logic [2*DATA_W-1:0] host_rdata,
    output logic [SEL_W-1:0]    clk_sel,
    output logic [DATA_W-1:0]   sel_fb_div,
    output logic [POST_W-1:0]   sel_post_code,
    output logic [DATA_W-1:0]   ref_div,
    output logic [DATA_W-1:0]   gen_ctl,
    output logic [DATA_W-1:0]   ext_ctl
);
    logic [DATA_W-1:0]         addr_q;
    logic [IDX_W-1:0]          idx;
    logic                      wen;
    logic                      addr_wr;
    logic                      data_wr;
    logic [NUM_CLK*DATA_W-1:0] fb_q;
    logic [DATA_W-1:0]         post_q;
    logic [DATA_W-1:0]         rd_byte;

    // Lane strobes; data lane qualified by the stored enable
    always_comb begin
        addr_wr = host_wr && host_be[0];
        data_wr = host_wr && host_be[1] && wen;
    end

    pllwin_addr_port u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_wr (addr_wr),
        .addr_in (host_wdata[DATA_W-1:0]),
        .addr_q  (addr_q),
        .idx     (idx),
        .wen     (wen)
    );

    pllwin_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .idx     (idx),
        .wdata   (host_wdata[2*DATA_W-1:DATA_W]),
        .fb_q    (fb_q),
        .post_q  (post_q),
        .ref_q   (ref_div),
        .gen_q   (gen_ctl),
        .ext_q   (ext_ctl),
        .sel_q   (clk_sel)
    );

    pllwin_read_mux u_rmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx),
        .fb_q    (fb_q),
        .post_q  (post_q),
        .ref_q   (ref_div),
        .gen_q   (gen_ctl),
        .ext_q   (ext_ctl),
        .sel_q   (clk_sel),
        .rd_byte (rd_byte)
    );

    pllwin_clk_view u_view (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_q    (clk_sel),
        .fb_q     (fb_q),
        .post_q   (post_q),
        .sel_fb   (sel_fb_div),
        .sel_post (sel_post_code)
    );

    // Read word: selected register over the stored address byte
    always_comb host_rdata = {rd_byte, addr_q};

    assert_prior_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_be[1] && !wen) |=> $stable({ref_div, gen_ctl, ext_ctl}));
endmodule

// File: tb/pll_reg_window_tb.sv
// Scoreboard bench: driver tasks queue expected values, a monitor on the
// falling edge pops and compares them against the design outputs.
module pll_reg_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_be = 2'b00;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [1:0]  clk_sel;
    logic [7:0]  sel_fb_div;
    logic [1:0]  sel_post_code;
    logic [7:0]  ref_div;
    logic [7:0]  gen_ctl;
    logic [7:0]  ext_ctl;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int    kind;
        int    exp;
        string req;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    pll_reg_window u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .clk_sel(clk_sel),
        .sel_fb_div(sel_fb_div), .sel_post_code(sel_post_code),
        .ref_div(ref_div), .gen_ctl(gen_ctl), .ext_ctl(ext_ctl)
    );

    // kinds: 0 data lane, 1 address lane, 2 sel_fb, 3 post code,
    //        4 ref, 5 gen, 6 ext, 7 clk_sel
    function automatic int probe(int kind);
        case (kind)
            0: return int'(host_rdata[15:8]);
            1: return int'(host_rdata[7:0]);
            2: return int'(sel_fb_div);
            3: return int'(sel_post_code);
            4: return int'(ref_div);
            5: return int'(gen_ctl);
            6: return int'(ext_ctl);
            default: return int'(clk_sel);
        endcase
    endfunction

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            int act;
            it  = sb_q.pop_front();
            act = probe(it.kind);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h",
                         it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_val(int kind, int exp, string req);
        sb_q.push_back('{kind, exp, req});
        wait (sb_q.size() == 0);
    endtask

    task automatic bus_write(logic [1:0] be, logic [7:0] a, logic [7:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_be = be; host_wdata = {d, a};
        @(posedge clk); #1;
        host_wr = 1'b0; host_be = 2'b00;
    endtask

    task automatic set_addr(int idx, bit we);
        bus_write(2'b01, {idx[5:0], we, 1'b0}, 8'h00);
    endtask

    task automatic put_data(logic [7:0] d);
        bus_write(2'b10, 8'h00, d);
    endtask

    task automatic reg_wr(int idx, logic [7:0] d);
        set_addr(idx, 1'b1);
        put_data(d);
        set_addr(idx, 1'b0);
    endtask

    task automatic reg_rd_check(int idx, int exp, string req);
        set_addr(idx, 1'b0);
        expect_val(0, exp, req);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        for (int k = 0; k < 8; k++) expect_val(k, 0, "R1");

        // R2: address byte capture and readback, spare bit dropped
        set_addr(2, 1'b1);
        expect_val(1, 8'h0A, "R2");
        bus_write(2'b01, 8'h0B, 8'h00);
        expect_val(1, 8'h0A, "R2");

        // R3: enabled write lands
        put_data(8'h5A);
        expect_val(4, 8'h5A, "R3");
        set_addr(2, 1'b0);
        expect_val(1, 8'h08, "R2");
        expect_val(0, 8'h5A, "R5");

        // R4: data write with enable clear ignored
        put_data(8'hFF);
        expect_val(4, 8'h5A, "R4");
        expect_val(0, 8'h5A, "R4");

        // R9: general and extended control indices
        reg_wr(3, 8'hC3);
        reg_wr(4, 8'h3C);
        expect_val(5, 8'hC3, "R9");
        expect_val(6, 8'h3C, "R9");

        // R6: feedback dividers at consecutive indices
        for (int n = 0; n < 4; n++) reg_wr(6 + n, 8'(8'h80 + 8'h11 * n));
        for (int n = 0; n < 4; n++)
            reg_rd_check(6 + n, 8'h80 + 8'h11 * n, "R6");

        // R7: packed post codes, ascending pattern
        reg_wr(5, 8'hE4);
        for (int n = 0; n < 4; n++) begin
            reg_wr(1, 8'(n));
            expect_val(7, n, "R8");
            expect_val(2, 8'h80 + 8'h11 * n, "R6");
            expect_val(3, n, "R7");
        end
        // R7: descending pattern
        reg_wr(5, 8'h1B);
        for (int n = 0; n < 4; n++) begin
            reg_wr(1, 8'(n));
            expect_val(3, 3 - n, "R7");
        end

        // R8: selector keeps only two bits
        reg_wr(1, 8'hFF);
        expect_val(7, 3, "R8");
        reg_rd_check(1, 8'h03, "R8");
        expect_val(2, 8'hB3, "R6");

        // R5, R9: holes read zero and writes to them touch nothing
        reg_wr(0, 8'h77);
        reg_rd_check(0, 0, "R5");
        reg_wr(10, 8'h77);
        reg_rd_check(10, 0, "R5");
        reg_wr(63, 8'h77);
        reg_rd_check(63, 0, "R5");
        reg_rd_check(2, 8'h5A, "R9");
        reg_rd_check(3, 8'hC3, "R9");
        reg_rd_check(9, 8'hB3, "R9");

        // R10: both lanes in one cycle use the prior address
        set_addr(3, 1'b1);
        bus_write(2'b11, {6'd4, 1'b1, 1'b0}, 8'h33);
        expect_val(5, 8'h33, "R10");
        expect_val(6, 8'h3C, "R10");
        expect_val(1, 8'h12, "R10");
        put_data(8'h44);
        expect_val(6, 8'h44, "R10");
        // R10: prior enable clear blocks a combined write that sets it
        set_addr(2, 1'b0);
        bus_write(2'b11, {6'd2, 1'b1, 1'b0}, 8'h99);
        expect_val(4, 8'h5A, "R10");

        // R1: reset in mid-run clears everything
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int k = 0; k < 8; k++) expect_val(k, 0, "R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule